// File: doc/BRIEF.md
# Burst Address Sequencer for a Four-Beat Memory Burst

This block produces the two least significant address bits for a four-beat burst in a synchronous flow-through memory. When a burst opens, it captures the starting two address bits. It then steps through the three remaining beats by itself, and it moves forward only on cycles where the advance input is asserted. It reports the current burst address and the index of the current beat within the burst.

Two beat orders are available. Interleaved order combines the start address with the beat index by bitwise XOR. Linear order adds the beat index to the start address and wraps modulo four. Either of two address strobes opens a burst: one from the processor and one from a cache controller. An open burst can be paused at any point by holding advance low. After the fourth beat the sequence returns to the starting address. All inputs are sampled on the rising edge of one clock. The order select is captured together with the start address, so a burst keeps its order until the next load.

Top module: `burst_addr_seq`

## Requirements
- R1: While synchronous reset `rst` is high at a rising edge, after that edge `burst_addr` is 0 and `beat_idx` is 0.
- R2: A high level on either `strobe_cpu` or `strobe_ctl` at a rising edge opens a burst. After that edge `beat_idx` is 0 and `burst_addr` equals the `start_addr` sampled at that edge.
- R3: With `order_sel` = 0 (linear order) captured at the load, beat k presents `burst_addr` = (start + k) mod 4.
- R4: With `order_sel` = 1 (interleaved order) captured at the load, beat k presents `burst_addr` = start XOR k.
- R5: At an edge where no strobe is high and `advance` is low, `burst_addr` and `beat_idx` keep their values.
- R6: At an edge where no strobe is high and `advance` is high, `beat_idx` increments by one. After beat 3 it returns to beat 0, and `burst_addr` returns to the start address.
- R7: When a strobe and `advance` are high at the same edge, the load wins: the burst restarts at beat 0 with the new start address.
- R8: `order_sel` and `start_addr` are sampled only at edges where a strobe is high. Changing them during a burst does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_cpu | input | 1 | Processor address strobe; opens a burst |
| strobe_ctl | input | 1 | Controller address strobe; opens a burst |
| start_addr | input | 2 | Starting low address bits of the burst |
| advance | input | 1 | Step to the next beat when high |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order |
| burst_addr | output | 2 | Current burst address bits |
| beat_idx | output | 2 | Index of the current beat, 0 to 3 |

## Verification
Both outputs come from registers loaded at the clock edge, so every result is due in the cycle that follows the edge at which its stimulus was sampled. This holds for a load, a step, a hold and a reset alike. The bench changes inputs on the falling edge and reads outputs 2 ns after the next rising edge. Each expected value therefore applies to exactly one edge's stimulus. Expected addresses come from the linear and XOR formulas applied to the start value the bench drove.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int unsigned ADDR_W    = 2;
    localparam int unsigned NUM_BEATS = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] baddr_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        baddr_t start;
        order_e order;
    } burst_ctx_t;

    localparam burst_ctx_t CTX_RESET = '{start: '0, order: ORD_LINEAR};

    function automatic baddr_t linear_addr(baddr_t s, baddr_t k);
        return baddr_t'(s + k);
    endfunction

    function automatic baddr_t interleave_addr(baddr_t s, baddr_t k);
        return s ^ k;
    endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   advance,
    output baddr_t beat
);

    baddr_t beat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (load) begin
            beat_q <= '0;
        end else if (advance) begin
            beat_q <= beat_q + 1'b1;
        end
    end

    assign beat = beat_q;

    // R7: a load restarts the count, whatever advance does in that cycle
    a_r7_load_first: assert property (@(posedge clk) disable iff (rst)
        load |=> (beat == '0));

    // R5: no load and no advance keeps the beat
    a_r5_hold_beat: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> $stable(beat));

    // R6: advance steps by one and wraps at the top
    a_r6_step_wrap: assert property (@(posedge clk) disable iff (rst)
        (!load && advance && (beat == baddr_t'(NUM_BEATS-1))) |=> (beat == '0));

endmodule

// File: rtl/burst_ctx_reg.sv
module burst_ctx_reg
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  baddr_t     start_in,
    input  order_e     order_in,
    output burst_ctx_t ctx
);

    burst_ctx_t ctx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= CTX_RESET;
        end else if (load) begin
            ctx_q <= '{start: start_in, order: order_in};
        end
    end

    assign ctx = ctx_q;

    // R8: start and order are frozen between loads
    a_r8_ctx_frozen: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(ctx));

endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_seq_pkg::*;
(
    input  burst_ctx_t ctx,
    input  baddr_t     beat,
    output baddr_t     addr
);

    baddr_t lin_a;
    baddr_t ilv_a;

    always_comb begin
        lin_a = linear_addr(ctx.start, beat);
        ilv_a = interleave_addr(ctx.start, beat);
        addr  = (ctx.order == ORD_INTERLEAVE) ? ilv_a : lin_a;
    end

    // R3/R4: beat 0 always presents the start address in either order
    always_comb begin
        if (beat == '0) begin
            a_r3_r4_beat0: assert (addr == ctx.start);
        end
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              advance,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] burst_addr,
    output logic [ADDR_W-1:0] beat_idx
);

    logic       load;
    baddr_t     beat;
    burst_ctx_t ctx;
    baddr_t     addr;
    order_e     order_in;

    assign load     = strobe_cpu | strobe_ctl;
    assign order_in = order_sel ? ORD_INTERLEAVE : ORD_LINEAR;

    burst_beat_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .advance (advance),
        .beat    (beat)
    );

    burst_ctx_reg u_ctx (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .start_in (start_addr),
        .order_in (order_in),
        .ctx      (ctx)
    );

    burst_addr_map u_map (
        .ctx  (ctx),
        .beat (beat),
        .addr (addr)
    );

    assign burst_addr = addr;
    assign beat_idx   = beat;

    // R1: reset clears both outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (burst_addr == '0 && beat_idx == '0));

    // R2: either strobe presents the sampled start address next cycle
    a_r2_load_start: assert property (@(posedge clk) disable iff (rst)
        load |=> (burst_addr == $past(start_addr)));

    // R5: a paused burst keeps its address
    a_r5_hold_addr: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> $stable(burst_addr));

endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe_cpu = 1'b0;
    logic       strobe_ctl = 1'b0;
    logic [1:0] start_addr = 2'd0;
    logic       advance = 1'b0;
    logic       order_sel = 1'b0;
    logic [1:0] burst_addr;
    logic [1:0] beat_idx;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;

    burst_addr_seq uut (
        .clk        (clk),
        .rst        (rst),
        .strobe_cpu (strobe_cpu),
        .strobe_ctl (strobe_ctl),
        .start_addr (start_addr),
        .advance    (advance),
        .order_sel  (order_sel),
        .burst_addr (burst_addr),
        .beat_idx   (beat_idx)
    );

    // vector: {use_ctl_strobe, order_sel, start[1:0]}
    localparam logic [3:0] VEC [8] = '{
        4'b0000, 4'b1001, 4'b0010, 4'b1011,
        4'b0100, 4'b1101, 4'b0110, 4'b1111
    };

    function automatic logic [1:0] exp_addr(logic [1:0] s, logic [1:0] k, logic m);
        return m ? (s ^ k) : 2'((s + k) & 2'b11);
    endfunction

    task automatic cyc(input logic r, input logic sc, input logic sk,
                       input logic [1:0] st, input logic adv, input logic m);
        @(negedge clk);
        rst = r; strobe_cpu = sc; strobe_ctl = sk;
        start_addr = st; advance = adv; order_sel = m;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [1:0] a_exp, input logic [1:0] b_exp);
        checks++;
        if (burst_addr !== a_exp || beat_idx !== b_exp) begin
            errors++;
            $display("FAIL %s: addr=%0d beat=%0d expected addr=%0d beat=%0d",
                     tag, burst_addr, beat_idx, a_exp, b_exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        cyc(1, 0, 0, 2'd3, 1, 1);
        cyc(1, 0, 0, 2'd3, 1, 1);
        chk("R1 reset state", 2'd0, 2'd0);

        // table walk: load, then five advances, order input flipped after load
        for (int i = 0; i < 8; i++) begin
            logic [1:0] s;
            logic m;
            logic sel;
            s = VEC[i][1:0];
            m = VEC[i][2];
            sel = VEC[i][3];
            cyc(0, !sel, sel, s, 0, m);
            chk("R2 load start", s, 2'd0);
            for (int k = 1; k <= 5; k++) begin
                cyc(0, 0, 0, ~s, 1, !m);
                chk(k == 4 ? "R6 wrap" : (m ? "R4 interleave (R8)" : "R3 linear (R8)"),
                    exp_addr(s, 2'(k), m), 2'(k));
            end
        end

        // R5: pause mid-burst
        cyc(0, 1, 0, 2'd1, 0, 0);
        cyc(0, 0, 0, 2'd0, 1, 0);
        chk("R3 linear step", 2'd2, 2'd1);
        for (int j = 0; j < 3; j++) begin
            cyc(0, 0, 0, 2'd3, 0, 1);
            chk("R5 hold", 2'd2, 2'd1);
        end
        cyc(0, 0, 0, 2'd0, 1, 0);
        chk("R5 resume", 2'd3, 2'd2);

        // R7: load together with advance restarts at beat 0
        cyc(0, 0, 1, 2'd2, 1, 1);
        chk("R7 load priority", 2'd2, 2'd0);
        cyc(0, 0, 0, 2'd0, 1, 0);
        chk("R7 then R4 step", 2'd3, 2'd1);

        // R2: both strobes together
        cyc(0, 1, 1, 2'd3, 0, 1);
        chk("R2 both strobes", 2'd3, 2'd0);
        cyc(0, 0, 0, 2'd0, 1, 0);
        chk("R4 interleave beat1", 2'd2, 2'd1);

        // R1: reset mid-burst
        cyc(1, 0, 0, 2'd0, 1, 0);
        chk("R1 reset mid-burst", 2'd0, 2'd0);
        cyc(0, 0, 0, 2'd3, 1, 1);
        chk("R8 post-reset order linear start 0", 2'd1, 2'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule